// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block is a processor-local interval timer. It keeps a free-running 32-bit up-counter that advances by one on every pulse of a tick-enable input, and a compare register that software may load with any value. When a tick moves the counter onto the compare value, the block raises a timer interrupt. That interrupt feeds the pending bit 15 of the processor's cause register. The interrupt stays raised until software writes the compare register again.

Software reaches both registers through a move-to/move-from register port, selected by register number: the counter is register 9 and the compare register is register 11. The usual way to schedule the next interrupt is to read the counter, add an interval, and write the sum to compare. A smaller interval gives an earlier interrupt. Writing compare also acknowledges the pending interrupt. The tick-enable input sets how fast the counter runs.

Top module: `cct_timer`

## Requirements
- R1: After reset the counter reads 0, the compare register reads 0 and `timerIrq` is low.
- R2: Each cycle with `tickEn` high and no counter write adds one to the counter. A cycle without a tick and without a counter write leaves the counter unchanged.
- R3: The counter wraps from 0xFFFFFFFF to 0 on the next tick.
- R4: A write with `regAddr` = 9 loads the counter with `regWrData` at the next edge. If a tick arrives in the same cycle, the written value wins and the tick is dropped. Ticks that follow count up from the written value.
- R5: A write with `regAddr` = 11 loads the compare register with any 32-bit value, and the value reads back unchanged.
- R6: `timerIrq` rises at the same clock edge at which a tick makes the counter equal to the compare value, and not before.
- R7: Once raised, `timerIrq` stays high through further ticks and counter writes until the compare register is written.
- R8: A compare write forces `timerIrq` low at the next edge. A match that a tick would produce in that same cycle is discarded.
- R9: A match is tested only on a tick. Writing compare equal to the current counter, or writing the counter equal to compare, does not raise `timerIrq`.
- R10: `regRdData` returns the counter when `regAddr` = 9 and the compare register when `regAddr` = 11. It returns 0 for any other number. Writes to other numbers change neither register nor the interrupt.
- R11: After the counter value C is read and C+k is written to compare, `timerIrq` stays low for k-1 ticks and rises on the k-th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-rate pulse; the counter advances one step per high cycle |
| regWrEn | input | 1 | Move-to strobe; writes `regWrData` to the register numbered by `regAddr` |
| regAddr | input | 5 | Register number for read and write (9 = counter, 11 = compare) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Move-from data for the register numbered by `regAddr` (combinational) |
| timerIrq | output | 1 | Latched timer interrupt, cause pending bit 15 |

## Verification
The counter and compare registers are both readable on the register port. A wrong count or a lost write therefore shows up on `regRdData` in the cycle right after the faulty edge. A fault in the equality path or in the interrupt flop shows up as `timerIrq` rising one or more ticks early or late. It can also show up as an interrupt that drops without a compare write, or that rises with no tick behind it. The sweep of scheduling intervals makes such a fault visible within one interval. The runs across the wrap point and the same-cycle write/tick collisions catch faults in the priority logic at the edge where the collision happens.

// File: rtl/cct_pkg.sv
package cct_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic loadCount;    // counter takes write data
    logic stepCount;    // counter advances by one
    logic loadCompare;  // compare takes write data
  } dpCtrl_t;

endpackage

// File: rtl/cct_datapath.sv
module cct_datapath
  import cct_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 5,
  parameter int COUNT_SEL   = 9,
  parameter int COMPARE_SEL = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  compareVal,
  output logic [CNT_W-1:0]  rdData,
  output logic              matchNext
);

  localparam logic [ADDR_W-1:0] COUNT_ADDR   = ADDR_W'(COUNT_SEL);
  localparam logic [ADDR_W-1:0] COMPARE_ADDR = ADDR_W'(COMPARE_SEL);
  localparam logic [CNT_W-1:0]  ONE          = CNT_W'(1);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] compareQ;
  logic [CNT_W-1:0] countInc;

  // Incremented value; wraps modulo 2^CNT_W
  assign countInc  = countQ + ONE;
  // Equality the next tick would produce
  assign matchNext = (countInc == compareQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (ctrl.loadCount) begin
      countQ <= wrData;
    end else if (ctrl.stepCount) begin
      countQ <= countInc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      compareQ <= '0;
    end else if (ctrl.loadCompare) begin
      compareQ <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == COUNT_ADDR) begin
      rdData = countQ;
    end else if (rdAddr == COMPARE_ADDR) begin
      rdData = compareQ;
    end
  end

  assign countVal   = countQ;
  assign compareVal = compareQ;

endmodule

// File: rtl/cct_control.sv
module cct_control
  import cct_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int COUNT_SEL   = 9,
  parameter int COMPARE_SEL = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              matchNext,
  output dpCtrl_t           ctrl,
  output logic              timerIrq
);

  localparam logic [ADDR_W-1:0] COUNT_ADDR   = ADDR_W'(COUNT_SEL);
  localparam logic [ADDR_W-1:0] COMPARE_ADDR = ADDR_W'(COMPARE_SEL);

  logic hitCount;
  logic hitCompare;
  logic irqQ;
  logic irqD;

  assign hitCount   = regWrEn && (regAddr == COUNT_ADDR);
  assign hitCompare = regWrEn && (regAddr == COMPARE_ADDR);

  // A counter write takes priority over a tick in the same cycle
  always_comb begin
    ctrl.loadCount   = hitCount;
    ctrl.stepCount   = tickEn && !hitCount;
    ctrl.loadCompare = hitCompare;
  end

  // Compare write acknowledges; otherwise a tick onto compare sets; else hold
  always_comb begin
    irqD = irqQ;
    if (hitCompare) begin
      irqD = 1'b0;
    end else if (ctrl.stepCount && matchNext) begin
      irqD = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ <= 1'b0;
    end else begin
      irqQ <= irqD;
    end
  end

  assign timerIrq = irqQ;

endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 5,
  parameter int COUNT_SEL   = 9,
  parameter int COMPARE_SEL = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  output logic              timerIrq
);

  dpCtrl_t          ctrl;
  logic             matchNext;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] compareVal;

  cct_control #(
    .ADDR_W(ADDR_W), .COUNT_SEL(COUNT_SEL), .COMPARE_SEL(COMPARE_SEL)
  ) u_control (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .matchNext(matchNext), .ctrl(ctrl), .timerIrq(timerIrq)
  );

  cct_datapath #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .COUNT_SEL(COUNT_SEL), .COMPARE_SEL(COMPARE_SEL)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(regWrData), .rdAddr(regAddr),
    .countVal(countVal), .compareVal(compareVal), .rdData(regRdData),
    .matchNext(matchNext)
  );

endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 5,
  parameter int COUNT_SEL   = 9,
  parameter int COMPARE_SEL = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CNT_W-1:0]  regWrData,
  input logic [CNT_W-1:0]  regRdData,
  input logic              timerIrq,
  input logic [CNT_W-1:0]  countVal,
  input logic [CNT_W-1:0]  compareVal
);

  localparam logic [ADDR_W-1:0] COUNT_ADDR   = ADDR_W'(COUNT_SEL);
  localparam logic [ADDR_W-1:0] COMPARE_ADDR = ADDR_W'(COMPARE_SEL);

  logic wrCount;
  logic wrCompare;
  assign wrCount   = regWrEn && (regAddr == COUNT_ADDR);
  assign wrCompare = regWrEn && (regAddr == COMPARE_ADDR);

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    tickEn && !wrCount |=> countVal == $past(countVal) + CNT_W'(1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn && !wrCount |=> $stable(countVal));

  p_load_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrCount |=> countVal == $past(regWrData));

  p_load_compare_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrCompare |=> compareVal == $past(regWrData));

  p_rise_on_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerIrq) |-> (countVal == compareVal) && $past(tickEn));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    timerIrq && !wrCompare |=> timerIrq);

  p_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrCompare |=> !timerIrq);

  p_read_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == COUNT_ADDR |-> regRdData == countVal);

  p_read_compare_r10: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == COMPARE_ADDR |-> regRdData == compareVal);

endmodule

bind cct_timer cct_timer_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .COUNT_SEL(COUNT_SEL), .COMPARE_SEL(COMPARE_SEL)
) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .timerIrq(timerIrq),
  .countVal(countVal), .compareVal(compareVal)
);

// File: tb/cct_timer_bench.sv
module cct_timer_bench;

  localparam logic [4:0] A_CNT = 5'd9;
  localparam logic [4:0] A_CMP = 5'd11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = 5'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        timerIrq;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cct_timer u_cct_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .timerIrq(timerIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: drive after falling edge, release 1 ns after the rising edge
  task automatic cyc(input logic t, input logic w, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    tickEn = t; regWrEn = w; regAddr = a; regWrData = d;
    @(posedge clk);
    #1;
    tickEn = 1'b0; regWrEn = 1'b0; regWrData = 32'd0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    regAddr = a;
    #0.5;
    v = regRdData;
  endtask

  logic [31:0] v;
  logic [31:0] c;

  initial begin
    #400000;
    fails++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'd0, timerIrq}, 32'd0);
    rd(A_CNT, v); chk("R1 count", v, 32'd0);
    rd(A_CMP, v); chk("R1 compare", v, 32'd0);

    // R2 ticks advance, idle holds
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, A_CNT, 32'd0);
    rd(A_CNT, v); chk("R2 five ticks", v, 32'd5);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, A_CNT, 32'd0);
    rd(A_CNT, v); chk("R2 idle hold", v, 32'd5);

    // R10 other numbers read zero, writes to them do nothing
    for (int a = 0; a < 32; a++) begin
      if (a != 9 && a != 11) begin
        rd(5'(a), v); chk("R10 unmapped read", v, 32'd0);
      end
    end
    cyc(1'b0, 1'b1, 5'd10, 32'h1234_5678);
    cyc(1'b0, 1'b1, 5'd8, 32'hFFFF_FFFF);
    rd(A_CNT, v); chk("R10 count untouched", v, 32'd5);
    rd(A_CMP, v); chk("R10 compare untouched", v, 32'd0);
    chk("R10 irq untouched", {31'd0, timerIrq}, 32'd0);

    // R11 / R6 sweep of scheduling intervals
    for (int k = 1; k <= 24; k++) begin
      rd(A_CNT, c);
      cyc(1'b0, 1'b1, A_CMP, c + 32'(k));
      for (int i = 1; i < k; i++) begin
        cyc(1'b1, 1'b0, A_CNT, 32'd0);
        chk("R11 early irq", {31'd0, timerIrq}, 32'd0);
      end
      cyc(1'b1, 1'b0, A_CNT, 32'd0);
      chk("R6 irq on match", {31'd0, timerIrq}, 32'd1);
      rd(A_CNT, v); chk("R11 count at match", v, c + 32'(k));
    end

    // R7 sticky through ticks and a counter write
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, A_CNT, 32'd0);
    chk("R7 after ticks", {31'd0, timerIrq}, 32'd1);
    cyc(1'b0, 1'b1, A_CNT, 32'd100);
    chk("R7 after count write", {31'd0, timerIrq}, 32'd1);

    // R8 compare write acknowledges
    cyc(1'b0, 1'b1, A_CMP, 32'd500);
    chk("R8 ack", {31'd0, timerIrq}, 32'd0);

    // R9 no fire from writes alone
    cyc(1'b0, 1'b1, A_CMP, 32'd100);
    chk("R9 compare==count write", {31'd0, timerIrq}, 32'd0);
    cyc(1'b0, 1'b0, A_CNT, 32'd0);
    chk("R9 still low", {31'd0, timerIrq}, 32'd0);
    cyc(1'b0, 1'b1, A_CMP, 32'd700);
    cyc(1'b0, 1'b1, A_CNT, 32'd700);
    chk("R9 count==compare write", {31'd0, timerIrq}, 32'd0);
    cyc(1'b1, 1'b0, A_CNT, 32'd0);
    chk("R9 tick past", {31'd0, timerIrq}, 32'd0);
    rd(A_CNT, v); chk("R9 count", v, 32'd701);

    // R4 write and tick collide: write wins
    cyc(1'b1, 1'b1, A_CNT, 32'h0000_0040);
    rd(A_CNT, v); chk("R4 write beats tick", v, 32'h40);
    cyc(1'b1, 1'b0, A_CNT, 32'd0);
    rd(A_CNT, v); chk("R4 tick after write", v, 32'h41);

    // R3 wrap, and a match across the wrap
    cyc(1'b0, 1'b1, A_CMP, 32'd1);
    cyc(1'b0, 1'b1, A_CNT, 32'hFFFF_FFFD);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, A_CNT, 32'd0);
    rd(A_CNT, v); chk("R3 wrap to zero", v, 32'd0);
    chk("R3 no irq at zero", {31'd0, timerIrq}, 32'd0);
    cyc(1'b1, 1'b0, A_CNT, 32'd0);
    chk("R3 irq after wrap", {31'd0, timerIrq}, 32'd1);

    // R8 compare write suppresses same-cycle match
    cyc(1'b0, 1'b1, A_CMP, 32'd201);
    cyc(1'b0, 1'b1, A_CNT, 32'd200);
    cyc(1'b1, 1'b1, A_CMP, 32'd205);
    chk("R8 match suppressed", {31'd0, timerIrq}, 32'd0);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, A_CNT, 32'd0);
    chk("R8 not yet", {31'd0, timerIrq}, 32'd0);
    cyc(1'b1, 1'b0, A_CNT, 32'd0);
    chk("R8 fires at new compare", {31'd0, timerIrq}, 32'd1);

    // R5 arbitrary compare value reads back
    cyc(1'b0, 1'b1, A_CMP, 32'hA5A5_5A5A);
    rd(A_CMP, v); chk("R5 compare readback", v, 32'hA5A5_5A5A);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule